// File: doc/BRIEF.md
# Bounded Binary-Search Fractional Divider

This block divides two signed fixed-point operands when the caller already knows the quotient magnitude cannot exceed one. A typical caller is an iterative motion-estimation loop that computes a small correction on each pass. Rather than run a general long division, the block treats A/B = x as the search for the x that makes B·x meet A. It resolves x one binary digit per clock, starting at the halfway point of the divisor, so the latency is fixed and short. On each step the block sets a trial bit and keeps it only if |A| is at least |B| times the trial fraction.

A caller pulses `start` with `a` and `b`. Exactly `N` cycles later `done` pulses and the result can be read. The result is a sign bit and an unsigned magnitude with one integer bit and `N` fraction bits. When `|a| ≥ |b|`, the magnitude clips to exactly one. A zero divisor raises a flag and returns zero. The result stays on the outputs until the next accepted start. A new operation can be accepted in the same cycle that `done` is high, which gives one result every `N` cycles.

Top module: `frac_bsearch_div`

## Requirements
- R1: `a` and `b` are W-bit two's complement values. `mag` is N+1 bits unsigned: bit N weighs 1.0 and bit k (for k < N) weighs 2^(k-N). When b ≠ 0 and |a| < |b|, `mag` equals floor(|a|·2^N / |b|) at `done`.
- R2: The quotient is truncated, never rounded. An exact multiple |a| = |b|·k/2^N gives exactly k.
- R3: When b ≠ 0 and |a| ≥ |b|, `mag` equals 2^N, which is 1.0.
- R4: When b ≠ 0, `neg` equals the XOR of the sign bits of `a` and `b`. This holds even when the magnitude is zero.
- R5: When b = 0, `div0` is 1, `mag` is 0 and `neg` is 0 at `done`. Otherwise `div0` is 0.
- R6: If `start` is accepted in cycle c, then `done` is high in cycle c+N, for that one cycle only.
- R7: `busy` is high from cycle c+1 through cycle c+N-1. While `busy` is high, `start` is ignored and changes neither the result nor the timing.
- R8: `start` is accepted in any cycle where `busy` is low, including the `done` cycle. Holding `start` high therefore gives a `done` every N cycles.
- R9: After `done`, `mag`, `neg` and `div0` hold their values until the next accepted start.
- R10: After reset, `done`, `busy`, `mag`, `neg` and `div0` are all 0.
- R11: The most negative operand value, -2^(W-1), is handled as magnitude 2^(W-1) in either operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with the present `a` and `b` |
| a | input | W | Signed dividend |
| b | input | W | Signed divisor |
| done | output | 1 | One-cycle pulse when the result is ready |
| busy | output | 1 | Search in progress; `start` is ignored |
| neg | output | 1 | Sign of the quotient |
| mag | output | N+1 | Quotient magnitude: 1 integer bit, N fraction bits |
| div0 | output | 1 | Divisor was zero |

## Verification
A start accepted at the rising edge that ends cycle c produces `done` and a valid result in cycle c+N. `busy` covers cycles c+1 to c+N-1. The bench model runs a per-edge countdown of N-1 from the accepting edge and publishes its expected result on the edge where the countdown reaches zero. The model is compared with the outputs at every falling edge, so each value is read half a period after the edge that made it. The magnitude and flags are compared only in cycles where the model says the unit is idle, because they are the finished result only then.

// File: rtl/frac_bsearch_div.sv
module frac_bsearch_div #(
  parameter int W = 12,
  parameter int N = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic                done,
  output logic                busy,
  output logic                neg,
  output logic [N:0]          mag,
  output logic                div0
);
  localparam int RW = W + N + 1;
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [N:0] ONE = {1'b1, {N{1'b0}}};

  logic [W-1:0]  a_abs, b_abs, b_q, cur_b;
  logic [RW-1:0] rem_q, cur_rem, trial;
  logic [IW-1:0] idx_q, cur_idx;
  logic [N-1:0]  q_q, q_next;
  logic          load, take, last;
  logic          neg_q, sat_q, zero_q;

  assign a_abs = a[W-1] ? W'(-a) : W'(a);
  assign b_abs = b[W-1] ? W'(-b) : W'(b);

  // first step reads the ports directly so N edges give N bits
  assign load    = start & ~busy;
  assign cur_rem = load ? (RW'(a_abs) << N) : rem_q;
  assign cur_b   = load ? b_abs : b_q;
  assign cur_idx = load ? IW'(N - 1) : idx_q;
  assign trial   = RW'(cur_b) << cur_idx;
  assign take    = cur_rem >= trial;
  assign last    = (cur_idx == '0);
  assign q_next  = (load ? '0 : q_q) | (N'(take) << cur_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      b_q    <= '0;
      idx_q  <= '0;
      q_q    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      neg_q  <= 1'b0;
      sat_q  <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load || busy) begin
        rem_q <= take ? (cur_rem - trial) : cur_rem;
        b_q   <= cur_b;
        idx_q <= cur_idx - IW'(1);
        q_q   <= q_next;
        busy  <= ~last;
        done  <= last;
      end
      if (load) begin
        neg_q  <= a[W-1] ^ b[W-1];
        sat_q  <= a_abs >= b_abs;
        zero_q <= (b == '0);
      end
    end
  end

  assign mag  = zero_q ? '0 : (sat_q ? ONE : {1'b0, q_q});
  assign neg  = neg_q & ~zero_q;
  assign div0 = zero_q;
endmodule

// File: rtl/frac_bsearch_div_chk.sv
module frac_bsearch_div_chk #(
  parameter int N = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       neg,
  input logic [N:0] mag,
  input logic       div0
);
  int cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cyc <= 0;
    else if (start && !busy)   cyc <= 1;
    else if (done)             cyc <= 0;
    else if (cyc != 0)         cyc <= cyc + 1;
  end

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cyc == N);
  p_due_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == N) |-> done);
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (N > 1 && done) |=> !done);
  p_busy_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  p_div0_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div0 |-> (mag == '0 && !neg));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(mag) && $stable(neg) && $stable(div0)));
endmodule

bind frac_bsearch_div frac_bsearch_div_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .neg(neg), .mag(mag), .div0(div0)
);

// File: tb/frac_bsearch_div_tb.sv
`timescale 1ns/1ps
module frac_bsearch_div_tb;
  localparam int W = 12;
  localparam int N = 6;
  localparam int ONE = 1 << N;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic signed [W-1:0] a = '0;
  logic signed [W-1:0] b = '0;
  logic                done, busy, neg, div0;
  logic [N:0]          mag;

  int checks = 0;
  int errors = 0;

  frac_bsearch_div #(.W(W), .N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
    .done(done), .busy(busy), .neg(neg), .mag(mag), .div0(div0)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void ref_div(input int av, input int bv,
                                  output int m, output bit n, output bit z);
    int aa, bb;
    aa = (av < 0) ? -av : av;
    bb = (bv < 0) ? -bv : bv;
    z = (bv == 0);
    if (z) begin m = 0; n = 1'b0; end
    else begin
      n = (av < 0) ^ (bv < 0);
      m = (aa >= bb) ? ONE : (aa * ONE) / bb;
    end
  endfunction

  // behavioural reference: countdown per edge after an accepted start
  bit m_busy, m_done, m_neg, m_div0;
  int m_mag, m_left;
  string m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_neg = 0; m_div0 = 0; m_mag = 0; m_left = 0;
      m_tag = "R10";
    end else begin
      m_done = 0;
      if (!m_busy && start) begin
        int pm; bit pn, pz;
        ref_div(int'(a), int'(b), pm, pn, pz);
        m_tag = pz ? "R5" : (pm == ONE ? "R3" : "R1");
        if (N == 1) begin
          m_done = 1; m_mag = pm; m_neg = pn; m_div0 = pz;
        end else begin
          m_busy = 1; m_left = N - 1;
          m_mag = pm; m_neg = pn; m_div0 = pz;
        end
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(done == m_done, "R6", "done", done, m_done);
      chk(busy == m_busy, "R7", "busy", busy, m_busy);
      if (!m_busy) begin
        chk(int'(mag) == m_mag, m_tag, "mag", mag, m_mag);
        chk(neg == m_neg, "R4", "neg", neg, m_neg);
        chk(div0 == m_div0, "R5", "div0", div0, m_div0);
      end
    end
  end

  task automatic run_op(input int av, input int bv, input string tag);
    int em; bit en, ez;
    ref_div(av, bv, em, en, ez);
    @(negedge clk);
    a = W'(av); b = W'(bv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(int'(mag) == em, tag, "mag", mag, em);
    chk(neg == en, tag, "neg", neg, en);
    chk(div0 == ez, tag, "div0", div0, ez);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0, "R10", "done", done, 0);
    chk(busy == 0, "R10", "busy", busy, 0);
    chk(mag == 0, "R10", "mag", mag, 0);
    chk(neg == 0, "R10", "neg", neg, 0);
    chk(div0 == 0, "R10", "div0", div0, 0);

    run_op(32, 64, "R1");
    run_op(-32, 64, "R4");
    run_op(56, -64, "R4");
    run_op(3, 7, "R1");
    run_op(100, 128, "R2");
    run_op(1, 3, "R2");
    run_op(2, 3, "R2");
    run_op(63, 64, "R2");
    run_op(100, 100, "R3");
    run_op(-200, 100, "R3");
    run_op(0, -5, "R4");
    run_op(5, 0, "R5");
    run_op(-5, 0, "R5");
    run_op(-2048, -2048, "R11");
    run_op(2047, -2048, "R11");
    run_op(-2048, 2047, "R11");

    // R9: result holds while idle
    run_op(45, 90, "R9");
    repeat (4) @(negedge clk);
    chk(int'(mag) == 32, "R9", "held mag", mag, 32);

    // R7: start pulses while busy are ignored
    @(negedge clk);
    a = 10; b = 20; start = 1'b1;
    for (int i = 1; i < N; i++) begin
      @(negedge clk);
      a = 1; b = 1; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1, "R7", "done after ignored starts", done, 1);
    chk(int'(mag) == 32, "R7", "mag after ignored starts", mag, 32);

    // R8: start held high gives a result every N cycles
    begin
      int last_t, t, gaps;
      last_t = -1; t = 0; gaps = 0;
      @(negedge clk);
      start = 1'b1;
      for (int i = 0; i < 5 * N; i++) begin
        a = W'(i * 13 - 40); b = W'(97 + i);
        @(negedge clk);
        t++;
        if (done) begin
          if (last_t >= 0) begin
            chk(t - last_t == N, "R8", "done spacing", t - last_t, N);
            gaps++;
          end
          last_t = t;
        end
      end
      start = 1'b0;
      chk(gaps >= 3, "R8", "back-to-back results", gaps, 3);
      repeat (N + 2) @(negedge clk);
    end

    for (int i = 0; i < 300; i++) begin
      int av, bv;
      av = int'($signed(W'($urandom)));
      bv = (i % 3 == 0) ? int'($urandom_range(0, 40)) - 20
                        : int'($signed(W'($urandom)));
      run_op(av, bv, "R1");
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule